// File: doc/BRIEF.md
# One-Bit Stream Table-Lookup FIR Filter

This block filters the one-bit output of a sigma-delta modulator comparator and produces a signed multi-bit sample. Each accepted bit enters a tap window. Every tap contributes its coefficient with a plus sign when its bit is 1 and with a minus sign when its bit is 0. No tap is ever left out of the sum. The filter has no multipliers and no adder per tap. The window is cut into groups of up to six neighbouring taps. Each group addresses a small constant table that holds every signed combination of that group's coefficients. One adder tree then sums the outputs of the tables.

The coefficients are a packed parameter. The tables are computed from them at elaboration, so the block needs no memory load at run time. A new sample may arrive on any cycle, with gaps of any length between samples. The block has no decimation: each accepted bit produces one output sample once the window is full.

Top module: `bitlut_fir`

## Requirements
- R1: With window bits b[k] and coefficients w[k], each valid output equals the sum over all k of (b[k] ? +w[k] : -w[k]). Coefficient k is the signed CW-bit field COEFS[k*CW +: CW].
- R2: Tap k holds the k-th most recent accepted bit, with k=0 the newest. Inside a group the newest tap drives the most significant table address bit.
- R3: The taps are grouped six at a time starting from tap 0. When NTAPS is not a multiple of six, the last group is smaller. The result is the same for NTAPS values that are multiples of six and for values that are not.
- R4: The window shifts only on cycles with din_vld high. Idle cycles produce no output and do not change later results.
- R5: dout_vld is high exactly two clock edges after the edge that accepts a bit, and dout then carries the result for the window that includes that bit.
- R6: Synchronous reset clears the window and the pipeline. dout_vld is low during reset and stays low until NTAPS bits have been accepted after reset.
- R7: dout is signed and CW+$clog2(NTAPS+1) bits wide. All-ones and all-zeros windows give +sum(w) and -sum(w) without wrap-around, including the case where every coefficient is the most negative value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din_vld | input | 1 | Input bit strobe |
| din | input | 1 | Modulator comparator bit |
| dout_vld | output | 1 | Output sample strobe |
| dout | output | CW+$clog2(NTAPS+1) | Signed filtered sample |

## Verification
The bench runs four configurations against a direct per-tap reference: window lengths of 16 and 5, which leave a short last group, a window of 12, which fills its groups exactly, and a window of 8 whose coefficients are all the most negative value. A design that reversed the address order inside a group would pass on all-ones and all-zeros streams but fail on random streams. An off-by-one in the fill count would show up as one sample too many or one too few right after reset. A result one bit too narrow would report -256 instead of +256 on the all-zeros stream of the last configuration. Random gaps in din_vld expose a window that shifts on idle cycles, or a valid strobe that arrives one cycle early or late.

// File: rtl/bitlut_fir.sv
module bitlut_fir #(
  parameter int NTAPS = 16,
  parameter int CW = 12,
  parameter int GSZ = 6,
  parameter logic [NTAPS*CW-1:0] COEFS = {NTAPS{CW'(1)}},
  localparam int OW = CW + $clog2(NTAPS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 din_vld,
  input  logic                 din,
  output logic                 dout_vld,
  output logic signed [OW-1:0] dout
);
  localparam int NG = (NTAPS + GSZ - 1) / GSZ;
  localparam int CNTW = $clog2(NTAPS + 1);

  function automatic logic signed [OW-1:0] entry(int base, int sz, int a);
    logic signed [OW-1:0] acc;
    logic signed [CW-1:0] w;
    acc = '0;
    for (int j = 0; j < sz; j++) begin
      w = COEFS[(base+j)*CW +: CW];
      if (a[sz-1-j]) acc = acc + OW'(w);
      else           acc = acc - OW'(w);
    end
    return acc;
  endfunction

  logic [NTAPS-1:0]     win;
  logic [CNTW-1:0]      cnt;
  logic                 s0, s1;
  logic signed [OW-1:0] look [NG];
  logic signed [OW-1:0] lut_q [NG];
  logic signed [OW-1:0] total;

  for (genvar g = 0; g < NG; g++) begin : grp
    localparam int BASE = g * GSZ;
    localparam int SZ = (NTAPS - BASE < GSZ) ? NTAPS - BASE : GSZ;
    logic [SZ-1:0]        addr;
    logic signed [OW-1:0] rom [2**SZ];
    for (genvar j = 0; j < SZ; j++) begin : abit
      assign addr[SZ-1-j] = win[BASE+j];
    end
    for (genvar a = 0; a < 2**SZ; a++) begin : row
      assign rom[a] = entry(BASE, SZ, a);
    end
    assign look[g] = rom[addr];
  end

  always_comb begin
    total = '0;
    for (int g = 0; g < NG; g++) total = total + lut_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win      <= '0;
      cnt      <= '0;
      s0       <= 1'b0;
      s1       <= 1'b0;
      dout_vld <= 1'b0;
      dout     <= '0;
      for (int g = 0; g < NG; g++) lut_q[g] <= '0;
    end else begin
      s0 <= din_vld && (cnt >= CNTW'(NTAPS - 1));
      if (din_vld) begin
        win <= (win << 1) | NTAPS'(din);
        if (cnt != CNTW'(NTAPS)) cnt <= cnt + 1'b1;
      end
      s1       <= s0;
      dout_vld <= s1;
      for (int g = 0; g < NG; g++) lut_q[g] <= look[g];
      dout     <= total;
    end
  end
endmodule

module bitlut_fir_chk #(
  parameter int NTAPS = 16,
  parameter int CW = 12,
  parameter logic [NTAPS*CW-1:0] COEFS = {NTAPS{CW'(1)}},
  localparam int OW = CW + $clog2(NTAPS + 1)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 din_vld,
  input logic                 dout_vld,
  input logic signed [OW-1:0] dout
);
  function automatic longint abs_sum();
    longint s = 0;
    logic signed [CW-1:0] w;
    for (int k = 0; k < NTAPS; k++) begin
      w = COEFS[k*CW +: CW];
      s += (w < 0) ? -longint'(w) : longint'(w);
    end
    return s;
  endfunction

  function automatic logic sum_lsb();
    logic p = 1'b0;
    for (int k = 0; k < NTAPS; k++) p ^= COEFS[k*CW];
    return p;
  endfunction

  localparam longint BOUND = abs_sum();
  localparam logic PAR = sum_lsb();
  localparam int SW = $clog2(NTAPS + 1) + 1;

  logic [SW-1:0] seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (din_vld && seen < SW'(NTAPS)) seen <= seen + 1'b1;
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    dout_vld |-> $past(din_vld, 3)); // R5
  AST_FILL: assert property (@(posedge clk) disable iff (rst)
    dout_vld |-> $past(seen, 3) >= SW'(NTAPS - 1)); // R6
  AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !dout_vld); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    dout_vld |-> (longint'(dout) <= BOUND && longint'(dout) >= -BOUND)); // R7
  AST_PARITY: assert property (@(posedge clk) disable iff (rst)
    dout_vld |-> dout[0] == PAR); // R1
endmodule

bind bitlut_fir bitlut_fir_chk #(.NTAPS(NTAPS), .CW(CW), .COEFS(COEFS)) u_chk (
  .clk(clk), .rst(rst), .din_vld(din_vld), .dout_vld(dout_vld), .dout(dout)
);

// File: tb/bitlut_fir_tb.sv
`timescale 1ns/1ps
module bitlut_fir_tb;
  localparam int NQ = 4;

  function automatic int coef_val(int k, int cw, int mode);
    int half = 1 << (cw - 1);
    if (mode == 1) return -half;
    if (k == 0) return -half;
    if (k == 1) return half - 1;
    if (k == 2) return -half;
    return ((k * 37 + 11) % (2 * half)) - half;
  endfunction

  function automatic logic [1023:0] pack_coefs(int n, int cw, int mode);
    logic [1023:0] v = '0;
    int c;
    for (int k = 0; k < n; k++) begin
      c = coef_val(k, cw, mode);
      for (int b = 0; b < cw; b++) v[k*cw + b] = c[b];
    end
    return v;
  endfunction

  localparam logic [1023:0] PA = pack_coefs(16, 12, 0);
  localparam logic [1023:0] PB = pack_coefs(12, 10, 0);
  localparam logic [1023:0] PC = pack_coefs(5, 8, 0);
  localparam logic [1023:0] PD = pack_coefs(8, 6, 1);
  localparam int OWA = 12 + $clog2(17);
  localparam int OWB = 10 + $clog2(13);
  localparam int OWC = 8 + $clog2(6);
  localparam int OWD = 6 + $clog2(9);

  int    nn [NQ] = '{16, 12, 5, 8};
  int    cws [NQ] = '{12, 10, 8, 6};
  int    modes [NQ] = '{0, 0, 0, 1};
  string names [NQ] = '{"R3 N=16", "R3 N=12", "R3 N=5", "R7 N=8"};

  logic clk = 1'b0;
  logic rst, din_vld, din;
  always #2.5 clk = ~clk;

  logic vA, vB, vC, vD;
  logic signed [OWA-1:0] dA;
  logic signed [OWB-1:0] dB;
  logic signed [OWC-1:0] dC;
  logic signed [OWD-1:0] dD;

  bitlut_fir #(.NTAPS(16), .CW(12), .COEFS(PA[16*12-1:0])) u_dut (
    .clk(clk), .rst(rst), .din_vld(din_vld), .din(din), .dout_vld(vA), .dout(dA));
  bitlut_fir #(.NTAPS(12), .CW(10), .COEFS(PB[12*10-1:0])) u_dut_b (
    .clk(clk), .rst(rst), .din_vld(din_vld), .din(din), .dout_vld(vB), .dout(dB));
  bitlut_fir #(.NTAPS(5), .CW(8), .COEFS(PC[5*8-1:0])) u_dut_c (
    .clk(clk), .rst(rst), .din_vld(din_vld), .din(din), .dout_vld(vC), .dout(dC));
  bitlut_fir #(.NTAPS(8), .CW(6), .COEFS(PD[8*6-1:0])) u_dut_d (
    .clk(clk), .rst(rst), .din_vld(din_vld), .din(din), .dout_vld(vD), .dout(dD));

  logic   ov [NQ];
  longint od [NQ];
  assign ov[0] = vA; assign od[0] = longint'(dA);
  assign ov[1] = vB; assign od[1] = longint'(dB);
  assign ov[2] = vC; assign od[2] = longint'(dC);
  assign ov[3] = vD; assign od[3] = longint'(dD);

  int     checks = 0, failures = 0, it = 0, hcnt = 0;
  logic   hist [64];
  int     qc [NQ][$];
  longint qv [NQ][$];
  string  req = "R6";

  function automatic longint ref_sum(int i);
    longint acc = 0;
    int c;
    for (int k = 0; k < nn[i]; k++) begin
      c = coef_val(k, cws[i], modes[i]);
      acc += hist[k] ? longint'(c) : -longint'(c);
    end
    return acc;
  endfunction

  task automatic check_all();
    for (int i = 0; i < NQ; i++) begin
      if (qc[i].size() > 0 && qc[i][0] == it) begin
        checks++;
        if (!ov[i]) begin
          failures++;
          $display("FAIL R5 %s: missing valid at step %0d, actual vld=0 expected vld=1", names[i], it);
        end else if (od[i] != qv[i][0]) begin
          failures++;
          $display("FAIL %s %s: step %0d actual=%0d expected=%0d", req, names[i], it, od[i], qv[i][0]);
        end
        void'(qc[i].pop_front());
        void'(qv[i].pop_front());
      end else if (ov[i]) begin
        checks++;
        failures++;
        $display("FAIL R5 R6 %s: unexpected valid at step %0d, actual vld=1 expected vld=0", names[i], it);
      end
    end
  endtask

  task automatic cycle(input logic v, input logic b);
    @(negedge clk);
    it++;
    check_all();
    rst = 1'b0;
    din_vld = v;
    din = b;
    if (v) begin
      for (int k = 63; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = b;
      if (hcnt < 64) hcnt++;
      for (int i = 0; i < NQ; i++)
        if (hcnt >= nn[i]) begin
          qc[i].push_back(it + 3);
          qv[i].push_back(ref_sum(i));
        end
    end
  endtask

  task automatic do_reset(input int n);
    for (int r = 0; r < n; r++) begin
      @(negedge clk);
      it++;
      if (r > 0)
        for (int i = 0; i < NQ; i++) begin
          checks++;
          if (ov[i] !== 1'b0) begin
            failures++;
            $display("FAIL R6 %s: valid in reset, actual=%b expected=0", names[i], ov[i]);
          end
        end
      rst = 1'b1;
      din_vld = 1'b0;
      din = 1'b0;
      hcnt = 0;
      for (int i = 0; i < NQ; i++) begin
        qc[i].delete();
        qv[i].delete();
      end
    end
  endtask

  logic done = 1'b0;

  initial begin
    rst = 1'b1; din_vld = 1'b0; din = 1'b0;
    for (int k = 0; k < 64; k++) hist[k] = 1'b0;
    do_reset(4);
    req = "R6";
    for (int k = 0; k < 8; k++) cycle(1'b1, k[0]);
    req = "R1 R2 R4";
    for (int k = 0; k < 800; k++) cycle(($urandom % 10) < 7, $urandom % 2);
    req = "R7 ones";
    for (int k = 0; k < 40; k++) cycle(1'b1, 1'b1);
    req = "R7 zeros";
    for (int k = 0; k < 40; k++) cycle(1'b1, 1'b0);
    req = "R4 gaps";
    for (int k = 0; k < 90; k++) cycle((k % 3) != 2, k[1]);
    do_reset(3);
    req = "R6 refill";
    for (int k = 0; k < 20; k++) cycle(1'b1, 1'b1);
    req = "R1 R2";
    for (int k = 0; k < 400; k++) cycle(($urandom % 4) != 0, $urandom % 2);
    for (int k = 0; k < 6; k++) cycle(1'b0, 1'b0);
    for (int i = 0; i < NQ; i++) begin
      checks++;
      if (qc[i].size() != 0) begin
        failures++;
        $display("FAIL R5 %s: outputs never seen, actual pending=%0d expected=0", names[i], qc[i].size());
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule